// File: doc/BRIEF.md
# Fractional Duty PWM Generator

This block turns an 8-bit control byte into a pulse-width modulated output. The seven low bits of the byte set the high time in counter steps, against a fixed period of 256 clock cycles. Each step of the setting therefore adds 1/256 of the period, about 0.39%. The top bit flips the polarity of the finished waveform. The largest setting, 127, gives a high time just under half the period. A setting of zero gives no pulses at all.

An internal 8-bit phase counter runs freely and wraps every 256 clocks. Each period begins with the pulse: the raw output is high while the phase is below the active duty value. The duty field of the control byte is sampled only on the clock edge where the phase wraps to zero. A change in the middle of a period therefore never cuts a pulse short and never adds a partial one. The polarity bit goes through an XOR after the raw output register, so a change to it shows on the output in the same cycle. The control byte is a plain level input, not a stream, so it has no handshake and no back-pressure.

Top module: `pwm_frac_gen`

## Requirements
- R1: The output period is 256 clocks, and the number of high cycles of the uninverted output in each period equals the duty field, bits 6:0 of the control byte.
- R2: A duty field of 0 keeps the uninverted output low for the whole period.
- R3: Within a period the pulse is one contiguous run, occupying phase positions 0 to D-1, where D is the active duty.
- R4: With bit 7 of the control byte at 1, the output is the complement of the uninverted waveform: 256-D high cycles per period.
- R5: While synchronous reset is asserted, the output is low for a control byte with bit 7 at 0. The active duty resets to 0, so the period running when reset is released has no pulse.
- R6: A new duty value is adopted only at the edge where the phase wraps to zero. The period in progress completes with its old duty.
- R7: A change of bit 7 reaches the output within the same clock cycle, with no register stage in between.
- R8: With bit 7 at 1 and a duty of 0, the output stays high for the whole period.
- R9: A duty of 127, the largest value, gives 127 high cycles out of 256.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctrl_byte | input | 8 | Bit 7 selects inversion; bits 6:0 give the duty in steps of 1/256 |
| pwm_out | output | 1 | PWM waveform |

## Verification
The bench sweeps every duty value from 0 to 127 under both polarities and counts the high cycles across one exactly aligned period. An off-by-one in the comparison would show up as D+1 or D-1 highs, and a flipped polarity path as 256-D. A reference model of the phase checks the output in every cycle, so a pulse that lands in the wrong part of the period or is split in two is caught. A duty change made in the middle of a period must not shorten the pulse already running; a design that samples the duty at once would emit a truncated pulse. The bench also checks the all-low period after reset, the all-high output for zero duty when inverted, and that a change of polarity shows in the same cycle rather than after a register delay.

// File: rtl/pwm_frac_pkg.sv
package pwm_frac_pkg;
  // phase counter width sets the period (2**PHASE_W clocks)
  localparam int PHASE_W = 8;
  // duty field width; must stay narrower than the phase
  localparam int LEVEL_W = 7;
  localparam int CTRL_W  = LEVEL_W + 1;

  typedef logic [PHASE_W-1:0] phase_t;
  typedef logic [LEVEL_W-1:0] level_t;
endpackage

// File: rtl/pwm_phase_ctr.sv
module pwm_phase_ctr #(
  parameter int PHASE_W = pwm_frac_pkg::PHASE_W
) (
  input  logic               clk,
  input  logic               rst,
  output logic [PHASE_W-1:0] phase_q,
  output logic [PHASE_W-1:0] phase_nx,
  output logic               wrap_o
);
  localparam logic [PHASE_W-1:0] LAST = {PHASE_W{1'b1}};

  always_comb begin
    phase_nx = phase_q + {{(PHASE_W-1){1'b0}}, 1'b1};
    wrap_o   = (phase_q == LAST);
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_nx;
  end

  // R1
  phase_step_chk: assert property (@(posedge clk) disable iff (rst)
    ##1 (!$past(rst)) |-> (phase_q == $past(phase_q) + {{(PHASE_W-1){1'b0}}, 1'b1}));
endmodule

// File: rtl/pwm_level_cmp.sv
module pwm_level_cmp #(
  parameter int PHASE_W = pwm_frac_pkg::PHASE_W,
  parameter int LEVEL_W = pwm_frac_pkg::LEVEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [PHASE_W-1:0] phase_q,
  input  logic [PHASE_W-1:0] phase_nx,
  input  logic               wrap_i,
  input  logic [LEVEL_W-1:0] level_i,
  output logic               raw_q
);
  localparam int PAD_W = PHASE_W - LEVEL_W;

  logic [LEVEL_W-1:0] level_q;
  logic [LEVEL_W-1:0] level_nx;
  logic               raw_nx;

  always_comb begin
    // the duty is only taken over at the period boundary
    level_nx = wrap_i ? level_i : level_q;
    raw_nx   = ({{PAD_W{1'b0}}, level_nx} > phase_nx);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      level_q <= '0;
      raw_q   <= 1'b0;
    end else begin
      level_q <= level_nx;
      raw_q   <= raw_nx;
    end
  end

  // R6
  level_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap_i |=> $stable(level_q));
  // R2
  zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    (level_q == '0) |-> !raw_q);
  // R3
  pulse_start_chk: assert property (@(posedge clk) disable iff (rst)
    (phase_q == '0 && level_q != '0) |-> raw_q);
  // R3
  pulse_end_chk: assert property (@(posedge clk) disable iff (rst)
    (!raw_q && phase_q != '0) |=> (!raw_q || phase_q == '0));
endmodule

// File: rtl/pwm_pol_stage.sv
module pwm_pol_stage (
  input  logic raw_i,
  input  logic invert_i,
  output logic wave_o
);
  always_comb wave_o = raw_i ^ invert_i;
endmodule

// File: rtl/pwm_frac_gen.sv
module pwm_frac_gen #(
  parameter int PHASE_W = pwm_frac_pkg::PHASE_W,
  parameter int LEVEL_W = pwm_frac_pkg::LEVEL_W,
  localparam int CTRL_W = LEVEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_byte,
  output logic              pwm_out
);
  logic [PHASE_W-1:0] phase_q;
  logic [PHASE_W-1:0] phase_nx;
  logic               wrap;
  logic               raw;

  pwm_phase_ctr #(.PHASE_W(PHASE_W)) ctr_i (
    .clk      (clk),
    .rst      (rst),
    .phase_q  (phase_q),
    .phase_nx (phase_nx),
    .wrap_o   (wrap)
  );

  pwm_level_cmp #(.PHASE_W(PHASE_W), .LEVEL_W(LEVEL_W)) cmp_i (
    .clk      (clk),
    .rst      (rst),
    .phase_q  (phase_q),
    .phase_nx (phase_nx),
    .wrap_i   (wrap),
    .level_i  (ctrl_byte[LEVEL_W-1:0]),
    .raw_q    (raw)
  );

  pwm_pol_stage pol_i (
    .raw_i    (raw),
    .invert_i (ctrl_byte[CTRL_W-1]),
    .wave_o   (pwm_out)
  );

  // R5
  reset_low_chk: assert property (@(posedge clk)
    $past(rst) |-> !raw);
endmodule

// File: tb/pwm_frac_gen_tb.sv
module pwm_frac_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] ctrl = 8'h00;
  logic       pwm_out;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;
  int fail_prints = 0;

  // bench-side phase and duty model, built from R1/R6
  logic [7:0] m_ph  = 8'd0;
  logic [6:0] m_lvl = 7'd0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm_frac_gen dut_i (
    .clk       (clk),
    .rst       (rst),
    .ctrl_byte (ctrl),
    .pwm_out   (pwm_out)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_ph  <= 8'd0;
      m_lvl <= 7'd0;
    end else begin
      if (m_ph == 8'd255) m_lvl <= ctrl[6:0];
      m_ph <= m_ph + 8'd1;
    end
  end

  // per-cycle shape check, R3 with R4
  always @(negedge clk) begin
    if (!rst) begin
      logic exp_v;
      exp_v = ({1'b0, m_lvl} > m_ph) ^ ctrl[7];
      checks++;
      if (pwm_out !== exp_v) begin
        errors++;
        if (fail_prints < 20) begin
          fail_prints++;
          $display("FAIL R3 phase %0d: got %0b expected %0b", m_ph, pwm_out, exp_v);
        end
      end
    end
  end

  task automatic check(input string req, input int got, input int exp_v);
    checks++;
    if (got != exp_v) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp_v);
    end
  endtask

  // wait until the phase is 255, set control, then count highs over the next full period
  task automatic aligned_period(input logic [7:0] c, output int hi);
    @(negedge clk);
    while (m_ph != 8'd255) @(negedge clk);
    ctrl = c;
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      @(negedge clk);
      if (pwm_out) hi++;
    end
  endtask

  initial begin
    int hi;
    repeat (3) @(negedge clk);
    ctrl = 8'h05;
    @(negedge clk);
    // R5: output low during reset
    check("R5 reset output", int'(pwm_out), 0);
    rst = 1'b0;
    hi = 0;
    @(negedge clk);
    while (m_ph != 8'd0) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    // R5: no pulse in the period running at reset release
    check("R5 first period highs", hi, 0);

    // R1 R2 R9: full sweep, not inverted
    for (int d = 0; d < 128; d++) begin
      aligned_period({1'b0, 7'(d)}, hi);
      check(d == 0 ? "R2 zero duty" : (d == 127 ? "R9 max duty" : "R1 duty sweep"), hi, d);
    end
    // R4 R8: full sweep, inverted
    for (int d = 0; d < 128; d++) begin
      aligned_period({1'b1, 7'(d)}, hi);
      check(d == 0 ? "R8 inverted zero" : "R4 inverted sweep", hi, 256 - d);
    end

    // R6: change duty 40 -> 10 at phase 20, running period keeps 40
    aligned_period(8'd40, hi);
    check("R6 setup period", hi, 40);
    while (m_ph != 8'd20) @(negedge clk);
    ctrl = 8'd10;
    hi = 0;
    while (m_ph != 8'd0) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R6 period not truncated", hi, 20);
    hi = 0;
    for (int k = 0; k < 256; k++) begin
      if (pwm_out) hi++;
      @(negedge clk);
    end
    check("R6 next period new duty", hi, 10);

    // R7: polarity flip visible in the same cycle
    aligned_period(8'd50, hi);
    while (m_ph != 8'd30) @(negedge clk);
    check("R7 before flip", int'(pwm_out), 1);
    ctrl = 8'hB2;
    #1;
    check("R7 same-cycle flip high phase", int'(pwm_out), 0);
    while (m_ph != 8'd200) @(negedge clk);
    ctrl = 8'h32;
    #1;
    check("R7 same-cycle flip low phase", int'(pwm_out), 0);
    ctrl = 8'hB2;
    #1;
    check("R7 same-cycle flip back", int'(pwm_out), 1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most %0d", cyc, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule